// File: doc/BRIEF.md
# Highlight Chroma Suppressor

This block sits in a video pipeline after colour-space conversion and takes a stream of YUV pixels. It removes false colour from near-white areas of the picture. If a pixel's luma is not above a programmable threshold, the pixel passes through untouched. Above the threshold, both chroma components are pulled toward neutral. The pull grows linearly with the amount by which luma exceeds the threshold. Luma itself is never changed.

Each pixel travels with a valid strobe through a fixed two-stage pipeline. The threshold, slope and enable controls are sampled in the same cycle as the pixel, so they may change between pixels. When the block is disabled it still delays pixels by the same two cycles, so the stream timing does not depend on the enable input.

Top module: `hl_chroma_suppress`

## Requirements
- R1: A pixel whose luma is less than or equal to the threshold leaves with U and V equal to their input values. This includes luma exactly equal to the threshold.
- R2: The output Y always equals the input Y of the same pixel.
- R3: U and V are 8-bit offset-binary, with 128 meaning no colour. For luma Y above threshold T with slope code S (0..7), the gain is g = 256 - ((Y - T) << S). Each chroma output is 128 + trunc((C - 128) * g / 256), where trunc rounds toward zero.
- R4: When ((Y - T) << S) is 256 or more, the gain is zero and both U and V leave as exactly 128.
- R5: The distance of an output chroma value from 128 never exceeds that of its input, and it never lies on the opposite side of 128.
- R6: With the enable input low, U and V pass unchanged whatever the luma, and the latency stays the same.
- R7: valid_o is high exactly two clock cycles after valid_i was high, once per input pixel. The controls are taken from the same cycle as the pixel.
- R8: While reset is asserted, valid_o and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Suppression enable, sampled with the pixel |
| thresh_i | input | 8 | Luma threshold, sampled with the pixel |
| slope_i | input | 3 | Attenuation slope as a left-shift count, sampled with the pixel |
| valid_i | input | 1 | Input pixel valid |
| y_i | input | 8 | Input luma |
| u_i | input | 8 | Input U, offset-binary |
| v_i | input | 8 | Input V, offset-binary |
| valid_o | output | 1 | Output pixel valid |
| y_o | output | 8 | Output luma |
| u_o | output | 8 | Output U, offset-binary |
| v_o | output | 8 | Output V, offset-binary |

## Verification
The hardest case to reach is the narrow band just above the threshold, where the gain lies strictly between zero and unity. In this band, truncation toward zero of negative chroma differs from a plain arithmetic shift. The stimulus places luma one to a few codes above the threshold with high slope codes. It pairs these pixels with extreme chroma codes on both sides of 128, so the fractional products land on both rounding directions. A randomized sweep with per-pixel changes to the controls then covers the clamp edge, where (Y - T) << S crosses 256. The same sweep also confirms that controls are tied to their own pixel.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned GAIN_W  = PIX_W + 1;
  localparam int unsigned EXC_W   = PIX_W + (1 << SHIFT_W) - 1;
  localparam int unsigned N_CHR   = 2;

  typedef struct packed {
    logic [PIX_W-1:0] y;
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] v;
  } yuv_t;

  // distance of an offset-binary code from neutral, signed
  function automatic int chr_signed(logic [PIX_W-1:0] c);
    return int'(c) - int'(1 << (PIX_W - 1));
  endfunction
endpackage

// File: rtl/hcs_gain.sv
module hcs_gain
  import hcs_pkg::*;
(
  input  logic               en_i,
  input  logic [PIX_W-1:0]   y_i,
  input  logic [PIX_W-1:0]   thr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [GAIN_W-1:0]  gain_o
);
  localparam logic [GAIN_W-1:0] UNITY   = GAIN_W'(1 << PIX_W);
  localparam logic [EXC_W-1:0]  UNITY_X = EXC_W'(1 << PIX_W);

  logic [PIX_W-1:0] excess;
  logic [EXC_W-1:0] scaled;

  always_comb begin
    excess = (y_i > thr_i) ? (y_i - thr_i) : '0;
    scaled = EXC_W'(excess) << shift_i;
    if (!en_i)                gain_o = UNITY;
    else if (scaled >= UNITY_X) gain_o = '0;
    else                      gain_o = UNITY - GAIN_W'(scaled);
  end
endmodule

// File: rtl/hcs_chroma_scale.sv
module hcs_chroma_scale
  import hcs_pkg::*;
(
  input  logic [PIX_W-1:0]  c_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [PIX_W-1:0]  c_o
);
  localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));
  localparam int unsigned PROD_W = PIX_W + GAIN_W;

  logic              neg;
  logic [PIX_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic [PIX_W-1:0]  res;

  // sign-magnitude product: dropping low bits truncates toward zero
  always_comb begin
    neg  = c_i < MID;
    mag  = neg ? (MID - c_i) : (c_i - MID);
    prod = PROD_W'(mag) * PROD_W'(gain_i);
    res  = PIX_W'(prod >> PIX_W);
    c_o  = neg ? (MID - res) : (MID + res);
  end
endmodule

// File: rtl/hl_chroma_suppress.sv
module hl_chroma_suppress
  import hcs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PIX_W-1:0]   thresh_i,
  input  logic [SHIFT_W-1:0] slope_i,
  input  logic               valid_i,
  input  logic [PIX_W-1:0]   y_i,
  input  logic [PIX_W-1:0]   u_i,
  input  logic [PIX_W-1:0]   v_i,
  output logic               valid_o,
  output logic [PIX_W-1:0]   y_o,
  output logic [PIX_W-1:0]   u_o,
  output logic [PIX_W-1:0]   v_o
);
  logic [GAIN_W-1:0] gain_d;
  logic              s1_valid;
  yuv_t              s1_pix;
  logic [GAIN_W-1:0] s1_gain;
  logic [PIX_W-1:0]  s1_chr [N_CHR];
  logic [PIX_W-1:0]  sc_chr [N_CHR];
  logic              s2_valid;
  yuv_t              s2_pix;

  hcs_gain u_gain (
    .en_i   (en_i),
    .y_i    (y_i),
    .thr_i  (thresh_i),
    .shift_i(slope_i),
    .gain_o (gain_d)
  );

  // stage 1: pixel with its gain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_gain  <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_pix  <= '{y: y_i, u: u_i, v: v_i};
        s1_gain <= gain_d;
      end
    end
  end

  assign s1_chr[0] = s1_pix.u;
  assign s1_chr[1] = s1_pix.v;

  for (genvar gi = 0; gi < N_CHR; gi++) begin : g_chr
    hcs_chroma_scale u_scale (
      .c_i   (s1_chr[gi]),
      .gain_i(s1_gain),
      .c_o   (sc_chr[gi])
    );
  end

  // stage 2: scaled chroma
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_pix   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_pix <= '{y: s1_pix.y, u: sc_chr[0], v: sc_chr[1]};
    end
  end

  assign valid_o = s2_valid;
  assign y_o     = s2_pix.y;
  assign u_o     = s2_pix.u;
  assign v_o     = s2_pix.v;

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  p_luma_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> y_o == $past(y_i, 2));

  p_below_thr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(y_i <= thresh_i, 2) |->
      u_o == $past(u_i, 2) && v_o == $past(v_i, 2));

  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(!en_i, 2) |->
      u_o == $past(u_i, 2) && v_o == $past(v_i, 2));

  p_neutral_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(en_i && y_i > thresh_i &&
      ((EXC_W'(y_i - thresh_i) << slope_i) >= EXC_W'(1 << PIX_W)), 2) |->
      u_o == PIX_W'(1 << (PIX_W - 1)) && v_o == PIX_W'(1 << (PIX_W - 1)));

  p_no_growth_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |->
      chr_signed(u_o) * chr_signed($past(u_i, 2)) >= 0 &&
      chr_signed(u_o) * chr_signed(u_o) <=
        chr_signed($past(u_i, 2)) * chr_signed($past(u_i, 2)) &&
      chr_signed(v_o) * chr_signed($past(v_i, 2)) >= 0 &&
      chr_signed(v_o) * chr_signed(v_o) <=
        chr_signed($past(v_i, 2)) * chr_signed($past(v_i, 2)));
endmodule

// File: tb/hl_chroma_suppress_bench.sv
module hl_chroma_suppress_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en, vin;
  logic [7:0] thr, y, u, v;
  logic [2:0] slope;
  logic       valid_o;
  logic [7:0] y_o, u_o, v_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    int    y, u, v, iu, iv;
    string req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hl_chroma_suppress u_hl_chroma_suppress (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .thresh_i(thr), .slope_i(slope),
    .valid_i(vin), .y_i(y), .u_i(u), .v_i(v),
    .valid_o(valid_o), .y_o(y_o), .u_o(u_o), .v_o(v_o)
  );

  function automatic int model_c(int c, int yy, int t, int s, bit e);
    int ex, g, sv;
    ex = (yy > t) ? ((yy - t) << s) : 0;
    g  = (ex >= 256) ? 0 : 256 - ex;
    if (!e) g = 256;
    sv = c - 128;
    return 128 + (sv * g) / 256;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(string req, bit e, int t, int s, int yy, int uu, int vv);
    exp_t x;
    @(negedge clk);
    en = e; thr = 8'(t); slope = 3'(s); y = 8'(yy); u = 8'(uu); v = 8'(vv); vin = 1'b1;
    x.y = yy; x.iu = uu; x.iv = vv; x.req = req;
    x.u = model_c(uu, yy, t, s, e);
    x.v = model_c(vv, yy, t, s, e);
    sb.push_back(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vin = 1'b0;
      y = 8'h5A; u = 8'h00; v = 8'hFF;
    end
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        check("R7 spurious valid_o", 1, 0);
      end else begin
        exp_t x;
        int du, dv, iu, iv;
        x = sb.pop_front();
        check({x.req, " Y (R2)"}, int'(y_o), x.y);
        check({x.req, " U"}, int'(u_o), x.u);
        check({x.req, " V"}, int'(v_o), x.v);
        du = int'(u_o) - 128; iu = x.iu - 128;
        dv = int'(v_o) - 128; iv = x.iv - 128;
        check("R5 no growth/inversion",
              int'(du * iu >= 0 && du * du <= iu * iu &&
                   dv * iv >= 0 && dv * dv <= iv * iv), 1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    en = 1'b1; thr = 8'd0; slope = 3'd0; vin = 1'b1; y = 8'hFF; u = 8'h00; v = 8'hFF;
    repeat (3) @(negedge clk);
    check("R8 reset valid_o", int'(valid_o), 0);
    check("R8 reset data", int'({y_o, u_o, v_o}), 0);
    vin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: at and below threshold
    drive("R1 equal", 1, 100, 7, 100, 0, 255);
    drive("R1 below", 1, 100, 7, 10, 30, 200);
    drive("R1 zero", 1, 255, 7, 255, 1, 254);

    // R3: partial attenuation, both rounding sides
    drive("R3 half", 1, 100, 7, 101, 0, 255);
    drive("R3 s0", 1, 50, 0, 150, 27, 229);
    drive("R3 s3", 1, 200, 3, 203, 127, 129);
    drive("R3 odd", 1, 0, 0, 255, 0, 255);
    drive("R3 s5", 1, 20, 5, 25, 3, 250);

    // R4: clamp to neutral
    drive("R4 edge", 1, 100, 1, 228, 0, 255);
    drive("R4 far", 1, 0, 7, 255, 10, 240);
    drive("R4 s2", 1, 100, 2, 200, 60, 190);

    // R6: bypass with bright pixels
    drive("R6 bypass", 0, 0, 7, 255, 5, 250);
    drive("R6 bypass2", 0, 10, 3, 200, 128, 77);

    // R7: gaps between pixels, controls tied per pixel
    idle(3);
    drive("R7 gap", 1, 100, 7, 101, 64, 192);
    idle(1);
    drive("R7 ctl", 1, 50, 0, 100, 200, 40);
    drive("R7 ctl2", 0, 50, 0, 100, 200, 40);
    idle(2);

    // sweep
    for (int i = 0; i < 300; i++) begin
      drive("R3 sweep", 1'($urandom_range(0, 7) != 0), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      if ((i % 17) == 0) idle(1);
    end
    idle(6);
    check("R7 all pixels out", sb.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule